// File: doc/BRIEF.md
# Serial Audio Word Port

This block is the word-level core of a synchronous serial audio port. It keeps a transmit holding word and a receive word, both in a 24-bit internal format with the sample aligned to the most significant bit. It converts between that format and a serial word of 8, 12, 16 or 24 bits. If enabled, it reverses the bit order inside the selected length. Bit-serial clocking and the routing fabric outside the port are not part of the block. The block sees one strobe per transmitted word and one strobe per received word. It also sees separate frame-sync events for each direction. The outgoing word is presented in parallel, aligned to the least significant bit.

Software sees four word addresses: a format register, a mode register, a data address and a status address. A data write loads the transmit word. A data read returns the received word. Each direction has a wait-for-frame flag. The flag is set again whenever that direction's enable bit rises. While the flag is set, words move as zeros. The flag clears on a frame-sync event. In network mode, only an event carrying a 1 counts as a frame start. In normal mode, every event counts. Each word strobe sets the matching status flag. When the word passed the gate and the interrupt enable is set, the strobe also raises a one-cycle interrupt request.

Top module: `sap_word_port`

## Requirements
- R1: Address map (reg_addr). 0 is format: bits [1:0] length code, bits [6:2] divider field. 1 is mode: bit0 transmit enable, bit1 receive enable, bit2 network mode, bit3 bit reversal, bit4 transmit interrupt enable, bit5 receive interrupt enable. 2 is data: a write loads the transmit word, a read returns the received word. 3 is status, read-only: bit0 transmit-empty, bit1 receive-full, bit2 transmit frame flag, bit3 receive frame flag, bit4 transmit wait, bit5 receive wait. Format and mode read back as written.
- R2: After reset, status reads 0x31 (transmit-empty and both wait flags set). Format and mode read 0. tx_word is 0, rate_div is 1 and both interrupt outputs are low.
- R3: Length code 0, 1, 2 and 3 select 8, 12, 16 and 24 bits. rate_div equals the divider field plus one.
- R4: On a transmit strobe that passes the gate, tx_word becomes the held word shifted right by 24 minus the length and masked to the length. tx_word is visible in the cycle after the strobe.
- R5: On a receive strobe that passes the gate, the stored received word becomes rx_serial masked to the length and shifted left by 24 minus the length.
- R6: With the reversal bit set, both directions reverse the bit order within the selected length.
- R7: A strobe in a direction whose enable is clear, or whose wait flag is set, stores a zero word and raises no interrupt.
- R8: A mode write that takes an enable bit from 0 to 1 sets that direction's wait flag. Writing an enable that is already 1 leaves the flag unchanged.
- R9: In network mode, a frame event with value 1 sets the direction's frame flag and clears its wait flag. A frame event with value 0 clears the frame flag and leaves the wait flag unchanged.
- R10: In normal mode, every frame event sets the frame flag and clears the wait flag, whatever its value.
- R11: Every transmit strobe sets transmit-empty. Every receive strobe sets receive-full. A strobe that passes the gate with its interrupt enabled drives tx_irq or rx_irq high for exactly the following cycle.
- R12: A write to address 2 or address 3 clears transmit-empty. A read of address 2 clears receive-full.
- R13: When a strobe and a clearing access fall in the same cycle, the flag ends up set. A frame event does not clear a wait flag that an enable rise re-arms in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect only at address 2) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 24 | Write data |
| reg_rdata | output | 24 | Read data, combinational from reg_addr |
| rx_tick | input | 1 | One receive word has arrived |
| rx_serial | input | 24 | Arriving word, aligned to the least significant bit |
| rx_fs_evt | input | 1 | Receive frame-sync event |
| rx_fs_val | input | 1 | Value carried by the receive frame-sync event |
| tx_tick | input | 1 | One transmit word is due |
| tx_fs_evt | input | 1 | Transmit frame-sync event |
| tx_fs_val | input | 1 | Value carried by the transmit frame-sync event |
| tx_word | output | 24 | Outgoing word, aligned to the least significant bit |
| rx_irq | output | 1 | Receive interrupt request pulse |
| tx_irq | output | 1 | Transmit interrupt request pulse |
| rate_div | output | 6 | Frame-rate divider value |

## Verification
The properties assume that strobes and frame events are single-cycle pulses sampled on the rising edge. The clear properties hold only when no word strobe falls in the same cycle. The frame-start property holds only when no mode write coincides, because coincident cases follow the priority rule and are covered separately. The stimulus drives every strobe for exactly one cycle, changing it at the falling edge. Same-cycle collisions appear only in the dedicated priority scenario, where the set-wins outcome is checked at the status port.

// File: rtl/sap_pkg.sv
package sap_pkg;

   localparam int unsigned ADDR_W = 2;
   localparam int unsigned MODE_W = 6;
   localparam int unsigned STAT_W = 6;

   typedef enum logic [ADDR_W-1:0] {
      A_FMT  = 2'd0,
      A_MODE = 2'd1,
      A_DATA = 2'd2,
      A_STAT = 2'd3
   } sap_addr_e;

   // packed: first field is the most significant bit
   typedef struct packed {
      logic rx_irq_en;
      logic tx_irq_en;
      logic bit_rev;
      logic net_mode;
      logic rx_en;
      logic tx_en;
   } sap_mode_t;

endpackage

// File: rtl/sap_fmt.sv
// Combinational word shaper: length select, alignment, optional bit reversal.
module sap_fmt #(
   parameter int unsigned WORD_W      = 24,
   parameter int unsigned LEN_C0      = 8,
   parameter int unsigned LEN_C1      = 12,
   parameter int unsigned LEN_C2      = 16,
   parameter int unsigned LEN_C3      = 24,
   parameter bit          IS_TX       = 1'b0,
   parameter bit          HAS_REVERSE = 1'b1
) (
   input  logic [1:0]        len_code,
   input  logic              bit_rev,
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] dout
);

   localparam int unsigned SH_W = $clog2(WORD_W + 1);
   localparam logic [SH_W-1:0]   SH0 = SH_W'(WORD_W - LEN_C0);
   localparam logic [SH_W-1:0]   SH1 = SH_W'(WORD_W - LEN_C1);
   localparam logic [SH_W-1:0]   SH2 = SH_W'(WORD_W - LEN_C2);
   localparam logic [SH_W-1:0]   SH3 = SH_W'(WORD_W - LEN_C3);
   localparam logic [WORD_W-1:0] MK0 = WORD_W'((64'd1 << LEN_C0) - 64'd1);
   localparam logic [WORD_W-1:0] MK1 = WORD_W'((64'd1 << LEN_C1) - 64'd1);
   localparam logic [WORD_W-1:0] MK2 = WORD_W'((64'd1 << LEN_C2) - 64'd1);
   localparam logic [WORD_W-1:0] MK3 = WORD_W'((64'd1 << LEN_C3) - 64'd1);

   logic [SH_W-1:0]   sh;
   logic [WORD_W-1:0] mask;
   logic [WORD_W-1:0] plain;
   logic [WORD_W-1:0] turned;

   always_comb begin
      unique case (len_code)
         2'd0:    begin sh = SH0; mask = MK0; end
         2'd1:    begin sh = SH1; mask = MK1; end
         2'd2:    begin sh = SH2; mask = MK2; end
         default: begin sh = SH3; mask = MK3; end
      endcase
   end

   function automatic logic [WORD_W-1:0] flip(input logic [WORD_W-1:0] v);
      logic [WORD_W-1:0] r;
      for (int i = 0; i < WORD_W; i++) r[i] = v[WORD_W-1-i];
      return r;
   endfunction

   // A full-width mirror followed by one shift gives reversal inside the length.
   generate
      if (IS_TX) begin : g_tx
         logic [WORD_W-1:0] low;
         always_comb begin
            low    = (din >> sh) & mask;
            plain  = low;
            turned = flip(low) >> sh;
         end
      end else begin : g_rx
         logic [WORD_W-1:0] low;
         always_comb begin
            low    = din & mask;
            plain  = low << sh;
            turned = flip(low);
         end
      end
   endgenerate

   generate
      if (HAS_REVERSE) begin : g_rev
         assign dout = bit_rev ? turned : plain;
      end else begin : g_norev
         logic unused_rev;
         assign unused_rev = ^{bit_rev, turned};
         assign dout       = plain;
      end
   endgenerate

endmodule

// File: rtl/sap_lane.sv
// One direction: word register, status flag, frame flag, wait flag, interrupt pulse.
module sap_lane #(
   parameter int unsigned WORD_W      = 24,
   parameter int unsigned LEN_C0      = 8,
   parameter int unsigned LEN_C1      = 12,
   parameter int unsigned LEN_C2      = 16,
   parameter int unsigned LEN_C3      = 24,
   parameter bit          IS_TX       = 1'b0,
   parameter bit          HAS_REVERSE = 1'b1,
   parameter bit          FLAG_RST    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_tick,
   input  logic              frame_evt,
   input  logic              frame_val,
   input  logic              net_mode,
   input  logic              lane_en,
   input  logic              arm,
   input  logic              irq_en,
   input  logic              bit_rev,
   input  logic [1:0]        len_code,
   input  logic [WORD_W-1:0] src,
   input  logic              flag_clr,
   output logic [WORD_W-1:0] data_q,
   output logic              flag_q,
   output logic              frame_q,
   output logic              wait_q,
   output logic              irq_q
);

   logic [WORD_W-1:0] shaped;
   logic              pass;
   logic              frame_start;

   sap_fmt #(
      .WORD_W(WORD_W), .LEN_C0(LEN_C0), .LEN_C1(LEN_C1),
      .LEN_C2(LEN_C2), .LEN_C3(LEN_C3),
      .IS_TX(IS_TX), .HAS_REVERSE(HAS_REVERSE)
   ) u_fmt (
      .len_code(len_code),
      .bit_rev (bit_rev),
      .din     (src),
      .dout    (shaped)
   );

   assign pass        = lane_en && !wait_q;
   assign frame_start = frame_evt && (frame_val || !net_mode);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q  <= '0;
         flag_q  <= FLAG_RST;
         frame_q <= 1'b0;
         wait_q  <= 1'b1;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= word_tick && pass && irq_en;
         if (word_tick) data_q <= pass ? shaped : '0;
         // a strobe outranks a clearing access
         if (word_tick)     flag_q <= 1'b1;
         else if (flag_clr) flag_q <= 1'b0;
         if (frame_evt) frame_q <= net_mode ? frame_val : 1'b1;
         // re-arming outranks a frame start
         if (arm)              wait_q <= 1'b1;
         else if (frame_start) wait_q <= 1'b0;
      end
   end

endmodule

// File: rtl/sap_ctrl.sv
// Format and mode registers, divider and enable-rise detection.
module sap_ctrl
   import sap_pkg::*;
#(
   parameter int unsigned WORD_W = 24,
   parameter int unsigned DIV_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_fmt,
   input  logic              wr_mode,
   input  logic [WORD_W-1:0] wdata,
   output logic [DIV_W+1:0]  fmt_q,
   output sap_mode_t         mode_q,
   output logic [1:0]        len_code,
   output logic [DIV_W:0]    rate_div,
   output logic              tx_arm,
   output logic              rx_arm
);

   localparam int unsigned FMT_W = DIV_W + 2;

   sap_mode_t wmode;
   assign wmode = sap_mode_t'(wdata[MODE_W-1:0]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fmt_q  <= '0;
         mode_q <= '0;
      end else begin
         if (wr_fmt)  fmt_q  <= wdata[FMT_W-1:0];
         if (wr_mode) mode_q <= wmode;
      end
   end

   assign tx_arm   = wr_mode && wmode.tx_en && !mode_q.tx_en;
   assign rx_arm   = wr_mode && wmode.rx_en && !mode_q.rx_en;
   assign len_code = fmt_q[1:0];
   assign rate_div = {1'b0, fmt_q[FMT_W-1:2]} + (DIV_W+1)'(1);

endmodule

// File: rtl/sap_word_port.sv
module sap_word_port
   import sap_pkg::*;
#(
   parameter int unsigned WORD_W      = 24,
   parameter int unsigned DIV_W       = 5,
   parameter int unsigned LEN_C0      = 8,
   parameter int unsigned LEN_C1      = 12,
   parameter int unsigned LEN_C2      = 16,
   parameter int unsigned LEN_C3      = 24,
   parameter bit          HAS_REVERSE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   input  logic              rx_tick,
   input  logic [WORD_W-1:0] rx_serial,
   input  logic              rx_fs_evt,
   input  logic              rx_fs_val,
   input  logic              tx_tick,
   input  logic              tx_fs_evt,
   input  logic              tx_fs_val,
   output logic [WORD_W-1:0] tx_word,
   output logic              rx_irq,
   output logic              tx_irq,
   output logic [DIV_W:0]    rate_div
);

   localparam int unsigned FMT_W = DIV_W + 2;

   generate
      if (WORD_W > 32 || WORD_W < FMT_W || WORD_W < MODE_W || WORD_W < STAT_W) begin : g_bad_w
         $error("sap_word_port: WORD_W does not fit the register fields");
      end
      if (LEN_C0 == 0 || LEN_C1 == 0 || LEN_C2 == 0 || LEN_C3 == 0 ||
          LEN_C0 > WORD_W || LEN_C1 > WORD_W || LEN_C2 > WORD_W || LEN_C3 > WORD_W) begin : g_bad_len
         $error("sap_word_port: word lengths must lie in 1..WORD_W");
      end
   endgenerate

   logic [FMT_W-1:0]  fmt_q;
   sap_mode_t         mode_q;
   logic [1:0]        len_code;
   logic              tx_arm, rx_arm;
   logic [WORD_W-1:0] tx_hold;
   logic [WORD_W-1:0] rx_data;
   logic              tx_empty, rx_full;
   logic              tx_frame, rx_frame;
   logic              tx_wait, rx_wait;
   logic              tx_en_q, rx_en_q;

   logic wr_fmt, wr_mode, wr_data, wr_stat, rd_data;
   assign wr_fmt  = reg_wr && (reg_addr == A_FMT);
   assign wr_mode = reg_wr && (reg_addr == A_MODE);
   assign wr_data = reg_wr && (reg_addr == A_DATA);
   assign wr_stat = reg_wr && (reg_addr == A_STAT);
   assign rd_data = reg_rd && (reg_addr == A_DATA);

   sap_ctrl #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_fmt  (wr_fmt),
      .wr_mode (wr_mode),
      .wdata   (reg_wdata),
      .fmt_q   (fmt_q),
      .mode_q  (mode_q),
      .len_code(len_code),
      .rate_div(rate_div),
      .tx_arm  (tx_arm),
      .rx_arm  (rx_arm)
   );

   assign tx_en_q = mode_q.tx_en;
   assign rx_en_q = mode_q.rx_en;

   always_ff @(posedge clk) begin
      if (!rst_n)       tx_hold <= '0;
      else if (wr_data) tx_hold <= reg_wdata;
   end

   sap_lane #(
      .WORD_W(WORD_W), .LEN_C0(LEN_C0), .LEN_C1(LEN_C1),
      .LEN_C2(LEN_C2), .LEN_C3(LEN_C3),
      .IS_TX(1'b1), .HAS_REVERSE(HAS_REVERSE), .FLAG_RST(1'b1)
   ) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .word_tick(tx_tick),
      .frame_evt(tx_fs_evt),
      .frame_val(tx_fs_val),
      .net_mode (mode_q.net_mode),
      .lane_en  (mode_q.tx_en),
      .arm      (tx_arm),
      .irq_en   (mode_q.tx_irq_en),
      .bit_rev  (mode_q.bit_rev),
      .len_code (len_code),
      .src      (tx_hold),
      .flag_clr (wr_data || wr_stat),
      .data_q   (tx_word),
      .flag_q   (tx_empty),
      .frame_q  (tx_frame),
      .wait_q   (tx_wait),
      .irq_q    (tx_irq)
   );

   sap_lane #(
      .WORD_W(WORD_W), .LEN_C0(LEN_C0), .LEN_C1(LEN_C1),
      .LEN_C2(LEN_C2), .LEN_C3(LEN_C3),
      .IS_TX(1'b0), .HAS_REVERSE(HAS_REVERSE), .FLAG_RST(1'b0)
   ) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .word_tick(rx_tick),
      .frame_evt(rx_fs_evt),
      .frame_val(rx_fs_val),
      .net_mode (mode_q.net_mode),
      .lane_en  (mode_q.rx_en),
      .arm      (rx_arm),
      .irq_en   (mode_q.rx_irq_en),
      .bit_rev  (mode_q.bit_rev),
      .len_code (len_code),
      .src      (rx_serial),
      .flag_clr (rd_data),
      .data_q   (rx_data),
      .flag_q   (rx_full),
      .frame_q  (rx_frame),
      .wait_q   (rx_wait),
      .irq_q    (rx_irq)
   );

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         A_FMT:   reg_rdata[FMT_W-1:0]  = fmt_q;
         A_MODE:  reg_rdata[MODE_W-1:0] = mode_q;
         A_DATA:  reg_rdata             = rx_data;
         default: reg_rdata[STAT_W-1:0] = {rx_wait, tx_wait, rx_frame, tx_frame, rx_full, tx_empty};
      endcase
   end

endmodule

// File: rtl/sap_word_port_chk.sv
module sap_word_port_chk #(
   parameter int unsigned WORD_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [1:0]        reg_addr,
   input logic [1:0]        en_bits,
   input logic              tx_tick,
   input logic              rx_tick,
   input logic              tx_fs_evt,
   input logic              tx_fs_val,
   input logic [WORD_W-1:0] tx_word,
   input logic              tx_irq,
   input logic              rx_irq,
   input logic              tx_empty,
   input logic              rx_full,
   input logic              tx_wait,
   input logic              rx_wait,
   input logic              tx_en_q,
   input logic              rx_en_q
);

   // R11: strobes always leave their flag set
   p_txflag_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
      tx_tick |=> tx_empty);
   p_rxflag_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_tick |=> rx_full);

   // R11 / R7: interrupts only follow a strobe that passed the gate
   p_txirq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |-> $past(tx_tick) && $past(tx_en_q) && !$past(tx_wait));
   p_rxirq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> $past(rx_tick) && $past(rx_en_q) && !$past(rx_wait));

   // R7: a gated transmit strobe sends zero
   p_tx_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_tick && (tx_wait || !tx_en_q) |=> tx_word == '0);

   // R8: enable rise re-arms the wait flag
   p_tx_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && reg_addr == 2'd1 && en_bits[0] && !tx_en_q |=> tx_wait);
   p_rx_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && reg_addr == 2'd1 && en_bits[1] && !rx_en_q |=> rx_wait);

   // R12: clearing accesses without a coincident strobe
   p_txclr_r12: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && reg_addr[1] && !tx_tick |=> !tx_empty);
   p_rxclr_r12: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd && reg_addr == 2'd2 && !rx_tick |=> !rx_full);

   // R9 / R10: a frame start with value 1 releases the transmit wait flag
   p_txfs_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_fs_evt && tx_fs_val && !(reg_wr && reg_addr == 2'd1) |=> !tx_wait);

endmodule

bind sap_word_port sap_word_port_chk #(.WORD_W(WORD_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .reg_rd   (reg_rd),
   .reg_addr (reg_addr),
   .en_bits  (reg_wdata[1:0]),
   .tx_tick  (tx_tick),
   .rx_tick  (rx_tick),
   .tx_fs_evt(tx_fs_evt),
   .tx_fs_val(tx_fs_val),
   .tx_word  (tx_word),
   .tx_irq   (tx_irq),
   .rx_irq   (rx_irq),
   .tx_empty (tx_empty),
   .rx_full  (rx_full),
   .tx_wait  (tx_wait),
   .rx_wait  (rx_wait),
   .tx_en_q  (tx_en_q),
   .rx_en_q  (rx_en_q)
);

// File: tb/sap_word_port_bench.sv
`timescale 1ns/1ps
module sap_word_port_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [23:0] reg_wdata = '0;
   logic [23:0] reg_rdata;
   logic        rx_tick = 1'b0, rx_fs_evt = 1'b0, rx_fs_val = 1'b0;
   logic [23:0] rx_serial = '0;
   logic        tx_tick = 1'b0, tx_fs_evt = 1'b0, tx_fs_val = 1'b0;
   logic [23:0] tx_word;
   logic        rx_irq, tx_irq;
   logic [5:0]  rate_div;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sap_word_port u_sap_word_port (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rx_tick(rx_tick), .rx_serial(rx_serial), .rx_fs_evt(rx_fs_evt),
      .rx_fs_val(rx_fs_val), .tx_tick(tx_tick), .tx_fs_evt(tx_fs_evt),
      .tx_fs_val(tx_fs_val), .tx_word(tx_word), .rx_irq(rx_irq),
      .tx_irq(tx_irq), .rate_div(rate_div)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_wr(input logic [1:0] a, input logic [23:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic do_rd(input logic [1:0] a, output logic [23:0] q);
      @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1; q = reg_rdata;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   task automatic stat_bit(input string tag, input int b, input logic exp);
      logic [23:0] q;
      do_rd(2'd3, q);
      check(tag, 32'(q[b]), 32'(exp));
   endtask

   task automatic pulse_tx();
      @(negedge clk); tx_tick = 1'b1;
      @(negedge clk); tx_tick = 1'b0;
   endtask

   task automatic pulse_rx(input logic [23:0] w);
      @(negedge clk); rx_tick = 1'b1; rx_serial = w;
      @(negedge clk); rx_tick = 1'b0;
   endtask

   task automatic fs_tx(input logic v);
      @(negedge clk); tx_fs_evt = 1'b1; tx_fs_val = v;
      @(negedge clk); tx_fs_evt = 1'b0;
   endtask

   task automatic fs_rx(input logic v);
      @(negedge clk); rx_fs_evt = 1'b1; rx_fs_val = v;
      @(negedge clk); rx_fs_evt = 1'b0;
   endtask

   task automatic t_reset();
      logic [23:0] q;
      do_rd(2'd3, q); check("R2 status after reset", 32'(q), 32'h31);
      do_rd(2'd0, q); check("R2 format after reset", 32'(q), 32'h0);
      do_rd(2'd1, q); check("R2 mode after reset", 32'(q), 32'h0);
      check("R2 tx_word after reset", 32'(tx_word), 32'h0);
      check("R2 rate_div after reset", 32'(rate_div), 32'd1);
      check("R2 irqs after reset", 32'({tx_irq, rx_irq}), 32'h0);
   endtask

   task automatic t_format();
      logic [23:0] q;
      do_wr(2'd0, 24'h1E);
      do_rd(2'd0, q); check("R1 format readback", 32'(q), 32'h1E);
      check("R3 divider 7+1", 32'(rate_div), 32'd8);
      do_wr(2'd0, 24'h7F);
      check("R3 divider 31+1", 32'(rate_div), 32'd32);
   endtask

   task automatic t_tx_shape();
      logic [23:0] q;
      do_wr(2'd1, 24'h05);
      do_rd(2'd1, q); check("R1 mode readback", 32'(q), 32'h05);
      fs_tx(1'b1);
      do_wr(2'd2, 24'hABCDEF);
      stat_bit("R12 data write clears tx empty", 0, 1'b0);
      do_wr(2'd0, 24'h02); pulse_tx();
      check("R4 tx 16-bit", 32'(tx_word), 32'hABCD);
      check("R11 no tx irq when disabled", 32'(tx_irq), 32'h0);
      stat_bit("R11 tx strobe sets empty", 0, 1'b1);
      do_wr(2'd0, 24'h00); pulse_tx();
      check("R4 tx 8-bit", 32'(tx_word), 32'hAB);
      do_wr(2'd0, 24'h01); pulse_tx();
      check("R4 tx 12-bit", 32'(tx_word), 32'hABC);
      do_wr(2'd0, 24'h03); pulse_tx();
      check("R4 tx 24-bit", 32'(tx_word), 32'hABCDEF);
      do_wr(2'd3, 24'h0);
      stat_bit("R12 dummy status write clears tx empty", 0, 1'b0);
      do_wr(2'd1, 24'h15);
      stat_bit("R8 enable kept high does not re-arm", 4, 1'b0);
      pulse_tx();
      check("R11 tx irq pulse", 32'(tx_irq), 32'h1);
      @(negedge clk);
      check("R11 tx irq single cycle", 32'(tx_irq), 32'h0);
   endtask

   task automatic t_rx_shape();
      logic [23:0] q;
      do_wr(2'd1, 24'h06);
      fs_rx(1'b1);
      do_wr(2'd0, 24'h02); pulse_rx(24'h123456);
      stat_bit("R11 rx strobe sets full", 1, 1'b1);
      do_rd(2'd2, q); check("R5 rx 16-bit", 32'(q), 32'h345600);
      stat_bit("R12 data read clears rx full", 1, 1'b0);
      do_wr(2'd0, 24'h00); pulse_rx(24'h123456);
      do_rd(2'd2, q); check("R5 rx 8-bit", 32'(q), 32'h560000);
      do_wr(2'd0, 24'h03); pulse_rx(24'h123456);
      do_rd(2'd2, q); check("R5 rx 24-bit", 32'(q), 32'h123456);
      do_wr(2'd1, 24'h26); pulse_rx(24'h000010);
      check("R11 rx irq pulse", 32'(rx_irq), 32'h1);
      @(negedge clk);
      check("R11 rx irq single cycle", 32'(rx_irq), 32'h0);
   endtask

   task automatic t_reverse();
      logic [23:0] q;
      do_wr(2'd1, 24'h0F);
      fs_tx(1'b1);
      do_wr(2'd2, 24'hA10000);
      do_wr(2'd0, 24'h00); pulse_tx();
      check("R6 tx reversed 8-bit", 32'(tx_word), 32'h85);
      do_wr(2'd0, 24'h01); pulse_rx(24'h000001);
      do_rd(2'd2, q); check("R6 rx reversed 12-bit", 32'(q), 32'h800000);
      do_wr(2'd0, 24'h02); pulse_rx(24'h00000C);
      do_rd(2'd2, q); check("R6 rx reversed 16-bit", 32'(q), 32'h300000);
   endtask

   task automatic t_gate();
      logic [23:0] q;
      do_wr(2'd0, 24'h00);
      do_wr(2'd1, 24'h14); pulse_tx();
      check("R7 tx disabled word", 32'(tx_word), 32'h0);
      check("R7 tx disabled irq", 32'(tx_irq), 32'h0);
      do_wr(2'd1, 24'h15);
      stat_bit("R8 tx enable rise re-arms", 4, 1'b1);
      pulse_tx();
      check("R7 tx waiting word", 32'(tx_word), 32'h0);
      check("R7 tx waiting irq", 32'(tx_irq), 32'h0);
      fs_tx(1'b1); pulse_tx();
      check("R7 tx released word", 32'(tx_word), 32'hA1);
      check("R7 tx released irq", 32'(tx_irq), 32'h1);
      do_wr(2'd1, 24'h24); pulse_rx(24'hFFFFFF);
      do_rd(2'd2, q); check("R7 rx disabled word", 32'(q), 32'h0);
   endtask

   task automatic t_net_fs();
      do_wr(2'd1, 24'h06);
      stat_bit("R8 rx enable rise re-arms", 5, 1'b1);
      fs_rx(1'b0);
      stat_bit("R9 value 0 clears rx frame", 3, 1'b0);
      stat_bit("R9 value 0 keeps rx wait", 5, 1'b1);
      fs_rx(1'b1);
      stat_bit("R9 value 1 sets rx frame", 3, 1'b1);
      stat_bit("R9 value 1 clears rx wait", 5, 1'b0);
      fs_rx(1'b0);
      stat_bit("R9 later value 0 clears rx frame", 3, 1'b0);
      stat_bit("R9 later value 0 leaves rx wait clear", 5, 1'b0);
   endtask

   task automatic t_norm_fs();
      do_wr(2'd1, 24'h00);
      do_wr(2'd1, 24'h03);
      stat_bit("R8 both waits re-armed", 4, 1'b1);
      fs_tx(1'b0);
      stat_bit("R10 normal tx frame set", 2, 1'b1);
      stat_bit("R10 normal tx wait cleared", 4, 1'b0);
      fs_rx(1'b0);
      stat_bit("R10 normal rx frame set", 3, 1'b1);
      stat_bit("R10 normal rx wait cleared", 5, 1'b0);
   endtask

   task automatic t_prio();
      logic [23:0] q;
      do_wr(2'd2, 24'h111111);
      @(negedge clk); reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 24'h222222; tx_tick = 1'b1;
      @(negedge clk); reg_wr = 1'b0; tx_tick = 1'b0;
      stat_bit("R13 tx strobe beats data write", 0, 1'b1);
      @(negedge clk); reg_rd = 1'b1; reg_addr = 2'd2; rx_tick = 1'b1; rx_serial = 24'h5;
      @(negedge clk); reg_rd = 1'b0; rx_tick = 1'b0;
      stat_bit("R13 rx strobe beats data read", 1, 1'b1);
      do_wr(2'd1, 24'h04);
      @(negedge clk); reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 24'h05;
      tx_fs_evt = 1'b1; tx_fs_val = 1'b1;
      @(negedge clk); reg_wr = 1'b0; tx_fs_evt = 1'b0;
      stat_bit("R13 re-arm beats frame start", 4, 1'b1);
      do_rd(2'd2, q);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_format();
      t_tx_shape();
      t_rx_shape();
      t_reverse();
      t_gate();
      t_net_fs();
      t_norm_fs();
      t_prio();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R1..: actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule